// File: doc/BRIEF.md
# Dual-Output Programmable Reference Divider

This block divides one reference clock by a programmable ratio R and feeds two phase-locked loops from that single counter. Loop A always receives one comparison event every R reference cycles. Loop B receives either the same rate or half of it, depending on a select input. For each loop the block gives a one-cycle strobe for edge-triggered phase detectors and a divided clock for level-based consumers.

Loop A is timed from the rising transition of the divided waveform. Loop B is timed from the falling transition. Because of this, the two loops never get their comparison events in the same reference cycle, and their charge pumps do not switch together.

A new ratio is accepted at any time, but the divider only takes it in at the end of the current period. Ratios below the legal minimum are raised to that minimum.

Top module: `refdiv_dual`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after, all four outputs are 0. The first `strobe_a_o` pulse comes exactly one cycle after the first edge at which `rst` is sampled low.
- R2: `strobe_a_o` is high for exactly one cycle in every R cycles, where R is the ratio in use.
- R3: `div_a_o` goes high in the same cycle as `strobe_a_o` and stays high for floor(R/2) cycles. It is low for the remaining R - floor(R/2) cycles.
- R4: When `half_b_i` = 0, `strobe_b_o` pulses in the cycle where `div_a_o` falls, which is floor(R/2) cycles after `strobe_a_o`. In this mode `div_b_o` equals `div_a_o`.
- R5: When `half_b_i` = 1, `strobe_b_o` pulses only on every second falling transition of `div_a_o`, so its period is 2R. `div_b_o` is a square wave that changes level on every falling transition of `div_a_o`.
- R6: `strobe_a_o` and `strobe_b_o` are never high in the same cycle.
- R7: A ratio value from 0 to 7 on `ratio_i` is treated as 8.
- R8: A change on `ratio_i` does not alter the period in progress. It takes effect from the period that starts after the current one ends.
- R9: The divide-by-2 stage advances on every falling transition of `div_a_o`, whatever `half_b_i` is. After reset, the first falling transition raises it, and in halved mode that transition produces a `strobe_b_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | 12 | Division ratio R (8 to 4095; smaller values are raised to 8) |
| half_b_i | input | 1 | 1 = loop B runs at half the loop A rate |
| strobe_a_o | output | 1 | One-cycle loop A comparison strobe |
| strobe_b_o | output | 1 | One-cycle loop B comparison strobe |
| div_a_o | output | 1 | Divided clock for loop A |
| div_b_o | output | 1 | Divided clock for loop B |

## Verification
The divider is run with the smallest ratio, an odd ratio, a mid-range ratio and the largest ratio. Together these show whether the high-phase length uses floor(R/2) and whether the terminal count is placed correctly. Ratios below 8 are applied to expose missing clamping. A ratio change in the middle of a period separates a design that loads at the terminal count from one that loads immediately. The select bit is changed while running, and reset is applied in the middle of a run. These two cases test whether the divide-by-2 stage keeps advancing in both modes and whether it restarts from a known phase.

// File: rtl/refdiv_dual.sv
module refdiv_dual #(
  parameter int RW   = 12,
  parameter int RMIN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ratio_i,
  input  logic          half_b_i,
  output logic          strobe_a_o,
  output logic          strobe_b_o,
  output logic          div_a_o,
  output logic          div_b_o
);
  localparam logic [RW-1:0] RMIN_V = RW'(RMIN);
  localparam logic [RW-1:0] ONE    = RW'(1);

  logic [RW-1:0] cnt;
  logic [RW-1:0] per;
  logic          tgl;

  logic [RW-1:0] req;
  logic [RW-1:0] half;
  logic          wrap;
  logic          fall;

  assign req  = (ratio_i < RMIN_V) ? RMIN_V : ratio_i;
  assign half = per >> 1;
  assign wrap = (cnt == per - ONE);
  assign fall = (cnt == half + ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      per <= req;
      tgl <= 1'b0;
    end else begin
      if (wrap) begin
        cnt <= '0;
        per <= req;
      end else begin
        cnt <= cnt + ONE;
      end
      if (cnt == half) tgl <= ~tgl;
    end
  end

  assign strobe_a_o = (cnt == ONE);
  assign div_a_o    = (cnt != '0) && (cnt <= half);
  assign strobe_b_o = fall && (!half_b_i || tgl);
  assign div_b_o    = half_b_i ? tgl : div_a_o;
endmodule

// File: rtl/refdiv_dual_chk.sv
module refdiv_dual_chk #(
  parameter int RW   = 12,
  parameter int RMIN = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [RW-1:0] ratio_i,
  input logic          half_b_i,
  input logic          strobe_a_o,
  input logic          strobe_b_o,
  input logic          div_a_o,
  input logic          div_b_o
);
  logic [4:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (strobe_a_o) begin
      gap  <= 5'd1;
      seen <= 1'b1;
    end else if (gap != 5'd31) begin
      gap <= gap + 5'd1;
    end
  end

  a_r6_disjoint: assert property (@(posedge clk) disable iff (rst)
    !(strobe_a_o && strobe_b_o));

  a_r2_single: assert property (@(posedge clk) disable iff (rst)
    strobe_a_o |=> !strobe_a_o);

  a_r3_rise_with_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe_a_o |-> div_a_o);

  a_r4_strobe_at_fall: assert property (@(posedge clk) disable iff (rst)
    (!half_b_i && $fell(div_a_o)) |-> strobe_b_o);

  a_r5_b_from_fall: assert property (@(posedge clk) disable iff (rst)
    strobe_b_o |-> !div_a_o);

  a_r7_min_period: assert property (@(posedge clk) disable iff (rst)
    (strobe_a_o && seen) |-> (gap >= 5'(RMIN)));
endmodule

bind refdiv_dual refdiv_dual_chk #(.RW(RW), .RMIN(RMIN)) u_chk (.*);

// File: tb/tb_refdiv_dual.sv
module tb_refdiv_dual;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] ratio_i = 12'd8;
  logic        half_b_i = 1'b0;
  logic        strobe_a_o, strobe_b_o, div_a_o, div_b_o;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit done    = 0;
  string tag  = "R1";

  int m_pos = 0, m_per = 8, m_t = 0;

  refdiv_dual dut (
    .clk(clk), .rst(rst), .ratio_i(ratio_i), .half_b_i(half_b_i),
    .strobe_a_o(strobe_a_o), .strobe_b_o(strobe_b_o),
    .div_a_o(div_a_o), .div_b_o(div_b_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clampr(int r);
    return (r < 8) ? 8 : r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_pos = 0; m_per = clampr(int'(ratio_i)); m_t = 0;
    end else begin
      if (m_pos == m_per / 2) m_t = 1 - m_t;
      if (m_pos == m_per - 1) begin
        m_pos = 0; m_per = clampr(int'(ratio_i));
      end else m_pos++;
    end
  end

  task automatic chk1(string req, string sig, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s (%s) %s: got %0b expected %0b at cycle %0d",
               req, tag, sig, got, exp, cycles);
    end
  endtask

  task automatic step();
    bit ea, eda, efall, eb, edb;
    string bq;
    @(posedge clk);
    #(CLK_PERIOD/4);
    ea    = (m_pos == 1);
    eda   = (m_pos >= 1) && (m_pos <= m_per / 2);
    efall = (m_pos == m_per / 2 + 1);
    eb    = efall && (!half_b_i || m_t == 1);
    edb   = half_b_i ? (m_t == 1) : eda;
    bq    = half_b_i ? "R5" : "R4";
    chk1("R2", "strobe_a", strobe_a_o, ea);
    chk1("R3", "div_a", div_a_o, eda);
    chk1(bq, "strobe_b", strobe_b_o, eb);
    chk1(bq, "div_b", div_b_o, edb);
    chk1("R6", "strobes_disjoint", strobe_a_o && strobe_b_o, 1'b0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    // R1: reset state and first strobe one cycle after release
    tag = "R1";
    run(3);
    chk1("R1", "reset_div_b", div_b_o, 1'b0);
    rst = 1'b0;
    step();
    chk1("R1", "first_strobe_a", strobe_a_o, 1'b1);
    run(40);
    // R3: odd ratio, floor high phase
    tag = "R3"; ratio_i = 12'd9; run(60);
    // R5 and R9: halved mode
    tag = "R9"; half_b_i = 1'b1; run(80);
    tag = "R5"; ratio_i = 12'd13; run(120);
    // R7: clamp of small ratios
    tag = "R7"; ratio_i = 12'd3; run(50);
    ratio_i = 12'd0; run(50);
    // R8: change mid period
    tag = "R8"; ratio_i = 12'd20; run(45);
    while (!strobe_a_o) step();
    run(3);
    ratio_i = 12'd11; run(60);
    // R4: select toggled while running
    tag = "R4"; half_b_i = 1'b0; run(37);
    half_b_i = 1'b1; run(29);
    half_b_i = 1'b0; run(40);
    // R1: reset mid run, then halved mode from a known phase (R9)
    tag = "R1"; rst = 1'b1; half_b_i = 1'b1; ratio_i = 12'd10; run(2);
    rst = 1'b0; tag = "R9"; run(60);
    // R2: largest ratio
    tag = "R2"; ratio_i = 12'd4095; run(4095 * 2 + 200);
    ratio_i = 12'd8; run(4200);
    finish_up();
  end
endmodule